// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel character into an asynchronous serial frame. A frame has a low start bit, then five to eight data bits sent least significant bit first, then an optional parity bit, then a high stop period. A 7-bit line-control input sets the word length, the parity scheme, the stop length and a break override. The transmitter reads it once per frame, when it accepts the character.

Bit timing comes from an external strobe, `baud_tick`, that pulses at sixteen times the bit rate. Each bit lasts a whole number of these ticks, so a stop length of one and a half bits is exact. Characters arrive over a valid/ready handshake. Ready is only raised when the line is idle and break is not asserted. While break is asserted the line is held low. After break is released the line sends one full bit time of mark before the next character may start.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, with break clear, `tx_out` is 1, `tx_ready` is 1 and `tx_busy` is 0.
- R2: A character is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle, `tx_busy` is 1, `tx_ready` is 0 and `tx_out` is 0 (the start bit) for 16 ticks.
- R3: Data bits follow the start bit, least significant first, 16 ticks each. The count is set by `line_ctrl[1:0]`: 00=5, 01=6, 10=7, 11=8 bits. Data bits above that count are ignored.
- R4: With `line_ctrl[3]`=0 there is no parity bit, and the stop period follows the last data bit directly.
- R5: With `line_ctrl[3]`=1 and `line_ctrl[5]`=0, a 16-tick parity bit follows the data. `line_ctrl[4]`=0 makes the total number of ones in data plus parity odd, and `line_ctrl[4]`=1 makes it even.
- R6: With `line_ctrl[3]`=1 and `line_ctrl[5]`=1, the parity bit is fixed regardless of data: 1 when `line_ctrl[4]`=0 and 0 when `line_ctrl[4]`=1.
- R7: The stop period drives `tx_out`=1. It lasts 16 ticks when `line_ctrl[2]`=0. When `line_ctrl[2]`=1 it lasts 24 ticks for 5-bit words and 32 ticks otherwise. `tx_ready` returns to 1 on the tick that ends it.
- R8: While `line_ctrl[6]`=1, `tx_out` is 0 in the same cycle and `tx_ready` is 0.
- R9: Once break has been held across a clock edge and then cleared, `tx_out` is 1 and `tx_ready` stays 0 until 16 ticks with break clear have passed.
- R10: Word length, parity and stop settings are captured when the character is accepted. Changing `line_ctrl[5:0]` during a frame does not alter that frame.
- R11: `tx_busy` changes only on a tick edge, or when a character is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter can take a character |
| line_ctrl | input | 7 | Format: [1:0] length, [2] long stop, [3] parity on, [4] even/space, [5] stick, [6] break |
| baud_tick | input | 1 | Strobe at 16 times the bit rate |
| tx_busy | output | 1 | Frame in progress |
| tx_out | output | 1 | Serial line |

## Verification
The start bit and busy appear in the cycle right after the accepting edge. Break acts on `tx_out` and `tx_ready` in the same cycle. Every later change falls on the edge that registers the 16th, 24th or 32nd tick of a bit period. The bench issues ticks one per cycle and samples each bit after its eighth tick, mid-bit, so a one-tick slip on any bit boundary does not hide a wrong value. Stop and guard lengths are measured by counting ticks until `tx_ready` returns, and each count is compared with 16, 24 or 32.

// File: rtl/uart_tx_pkg.sv
// Shared types for the frame transmitter: sequencer states, stop length
// codes, and the per-frame format captured on acceptance.
package uart_tx_pkg;

    // Positions inside the line-control input.
    localparam int LC_LONG_STOP = 2;
    localparam int LC_PAR_ON    = 3;
    localparam int LC_PAR_SEL   = 4;
    localparam int LC_STICK     = 5;
    localparam int LC_BREAK     = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GUARD,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_len_e;

    typedef struct packed {
        logic [2:0] last_bit;   // index of the final data bit (4..7)
        logic       par_en;
        logic       par_bit;
        stop_len_e  stop;
    } frame_fmt_t;

endpackage

// File: rtl/uart_tx_fmt.sv
// Decodes the line-control bits and the offered character into a frame
// format record, including the parity bit value.
// Assumes DATA_W is 8 or less, since the word length field selects 5..8 bits.
module uart_tx_fmt
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [5:0]        lc,
    input  logic [DATA_W-1:0] data,
    output frame_fmt_t        fmt
);

    logic [2:0]        last_bit;
    logic [DATA_W-1:0] used;
    logic              ones_odd;

    assign last_bit = 3'd4 + {1'b0, lc[1:0]};

    // Keep only the data bits that the selected word length sends.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign used[i] = data[i] & (3'(i) <= last_bit);
    end

    assign ones_odd = ^used;

    // Build the format record: stop length, parity enable and parity value.
    always_comb begin
        fmt.last_bit = last_bit;
        fmt.par_en   = lc[LC_PAR_ON];
        if (lc[LC_STICK]) begin
            fmt.par_bit = ~lc[LC_PAR_SEL];
        end else if (lc[LC_PAR_SEL]) begin
            fmt.par_bit = ones_odd;
        end else begin
            fmt.par_bit = ~ones_odd;
        end
        if (!lc[LC_LONG_STOP]) begin
            fmt.stop = STOP_ONE;
        end else if (lc[1:0] == 2'b00) begin
            fmt.stop = STOP_ONE_HALF;
        end else begin
            fmt.stop = STOP_TWO;
        end
    end

endmodule

// File: rtl/uart_tx_bittimer.sv
// Counts oversampling ticks within one bit period and flags the tick that
// completes a period of 'limit' ticks. Assumes limit is at least 1.
module uart_tx_bittimer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    assign done = tick && !clr && (cnt == limit - CNT_W'(1));

    // Advance the tick count, restarting after each completed period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/uart_tx_seq.sv
// Frame sequencer: takes a character on handshake, steps through start,
// data, parity and stop periods, and enforces one bit of mark after break.
// Assumes the bit timer reports period completion on bit_done.
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  frame_fmt_t        fmt_now,
    input  logic              brk,
    input  logic              bit_done,
    output logic              tmr_clr,
    output logic [CNT_W-1:0]  tmr_limit,
    output logic              tx_ready,
    output logic              tx_busy,
    output logic              line
);

    localparam logic [CNT_W-1:0] LIM_BIT  = CNT_W'(OVS);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OVS + OVS / 2);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OVS);

    tx_state_e         st, st_n;
    logic [DATA_W-1:0] shreg;
    logic [2:0]        bcnt;
    frame_fmt_t        fmt_q;
    logic              accept;

    assign tx_ready = (st == S_IDLE) && !brk;
    assign accept   = tx_valid && tx_ready;
    assign tx_busy  = (st == S_START) || (st == S_DATA) ||
                      (st == S_PAR)   || (st == S_STOP);
    assign tmr_clr  = (st == S_IDLE) || ((st == S_GUARD) && brk);

    // Choose the length of the current period in ticks.
    always_comb begin
        tmr_limit = LIM_BIT;
        if (st == S_STOP) begin
            case (fmt_q.stop)
                STOP_ONE_HALF: tmr_limit = LIM_HALF;
                STOP_TWO:      tmr_limit = LIM_TWO;
                default:       tmr_limit = LIM_BIT;
            endcase
        end
    end

    // Next-state selection for the frame sequence.
    always_comb begin
        st_n = st;
        case (st)
            S_IDLE: begin
                if (brk)         st_n = S_GUARD;
                else if (accept) st_n = S_START;
            end
            S_GUARD: if (!brk && bit_done) st_n = S_IDLE;
            S_START: if (bit_done) st_n = S_DATA;
            S_DATA: begin
                if (bit_done && (bcnt == fmt_q.last_bit)) begin
                    st_n = fmt_q.par_en ? S_PAR : S_STOP;
                end
            end
            S_PAR:  if (bit_done) st_n = S_STOP;
            S_STOP: if (bit_done) st_n = brk ? S_GUARD : S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // Level on the line for each state, before the break override.
    always_comb begin
        case (st)
            S_START: line = 1'b0;
            S_DATA:  line = shreg[0];
            S_PAR:   line = fmt_q.par_bit;
            default: line = 1'b1;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // Capture the character and format on accept, shift out data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
            fmt_q <= '0;
        end else if (accept) begin
            shreg <= tx_data;
            bcnt  <= '0;
            fmt_q <= fmt_now;
        end else if ((st == S_DATA) && bit_done) begin
            shreg <= shreg >> 1;
            bcnt  <= bcnt + 3'd1;
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Top of the frame transmitter. Joins the format decoder, the bit timer and
// the sequencer, and applies the break override to the serial line.
// Assumes baud_tick pulses for one clock at OVS times the bit rate.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [6:0]        line_ctrl,
    input  logic              baud_tick,
    output logic              tx_busy,
    output logic              tx_out
);

    localparam int CNT_W = $clog2(2 * OVS + 1);

    frame_fmt_t       fmt_now;
    logic             brk;
    logic             bit_done;
    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_limit;
    logic             line;

    assign brk    = line_ctrl[LC_BREAK];
    assign tx_out = line & ~brk;

    uart_tx_fmt #(.DATA_W(DATA_W)) u_fmt (
        .lc   (line_ctrl[5:0]),
        .data (tx_data),
        .fmt  (fmt_now)
    );

    uart_tx_bittimer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (baud_tick),
        .limit (tmr_limit),
        .done  (bit_done)
    );

    uart_tx_seq #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .fmt_now   (fmt_now),
        .brk       (brk),
        .bit_done  (bit_done),
        .tmr_clr   (tmr_clr),
        .tmr_limit (tmr_limit),
        .tx_ready  (tx_ready),
        .tx_busy   (tx_busy),
        .line      (line)
    );

endmodule

// File: rtl/uart_frame_tx_chk.sv
// Port-level properties of the frame transmitter, bound to its top.
module uart_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [6:0] line_ctrl,
    input logic       baud_tick,
    input logic       tx_busy,
    input logic       tx_out
);

    // R1: an idle line without break sits at mark.
    p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !line_ctrl[6]) |-> tx_out);

    // R2: an accepted character starts a frame with a low start bit.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (tx_busy && !tx_out && !tx_ready));

    // R2: no handshake while a frame is running.
    p_no_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !tx_ready);

    // R8: break forces the line low and blocks new characters.
    p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[6] |-> (!tx_out && !tx_ready));

    // R9: the cycle after break drops, no character is yet taken.
    p_guard_after_break_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_ctrl[6]) |-> !tx_ready);

    // R11: a running frame only ends on a tick edge.
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !baud_tick) |=> tx_busy);

    // R11: a frame only begins through the handshake.
    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !(tx_valid && tx_ready)) |=> !tx_busy);

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .line_ctrl (line_ctrl),
    .baud_tick (baud_tick),
    .tx_busy   (tx_busy),
    .tx_out    (tx_out)
);

// File: tb/uart_frame_tx_test.sv
// Directed bench for the frame transmitter: one task per scenario.
module uart_frame_tx_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic [6:0] line_ctrl;
    logic       baud_tick;
    logic       tx_busy;
    logic       tx_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_frame_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .line_ctrl (line_ctrl),
        .baud_tick (baud_tick),
        .tx_busy   (tx_busy),
        .tx_out    (tx_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One tick, driven from a falling edge; returns at the next falling edge.
    task automatic tick();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
        line_ctrl = 7'h00; baud_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_out", 32'(tx_out), 32'd1);
        check("R1 tx_ready", 32'(tx_ready), 32'd1);
        check("R1 tx_busy", 32'(tx_busy), 32'd0);
    endtask

    // Sends one frame with format lc; lc_mid replaces it after acceptance.
    task automatic t_frame(input string tag, input logic [7:0] d,
                           input logic [6:0] lc, input logic [6:0] lc_mid);
        int   n;
        int   nb;
        int   cnt;
        int   stop_exp;
        logic x;
        logic exp_bits[11];
        n = 5 + int'(lc[1:0]);
        x = 1'b0;
        exp_bits[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            exp_bits[1 + i] = d[i];
            x = x ^ d[i];
        end
        nb = 1 + n;
        if (lc[3]) begin
            if (lc[5])      exp_bits[nb] = ~lc[4];
            else if (lc[4]) exp_bits[nb] = x;
            else            exp_bits[nb] = ~x;
            nb++;
        end
        stop_exp = !lc[2] ? 16 : (n == 5 ? 24 : 32);

        line_ctrl = lc; tx_data = d; tx_valid = 1'b1;
        #1;
        check({"R2 ready ", tag}, 32'(tx_ready), 32'd1);
        @(negedge clk);
        tx_valid = 1'b0; tx_data = 8'h00; line_ctrl = lc_mid;
        check({"R2 busy ", tag}, 32'(tx_busy), 32'd1);
        check({"R2 start ", tag}, 32'(tx_out), 32'd0);
        repeat (3) @(negedge clk);
        check({"R11 busy hold ", tag}, 32'(tx_busy), 32'd1);
        for (int b = 0; b < nb; b++) begin
            ticks(8);
            if (b == 0)       check({"R2 start bit ", tag}, 32'(tx_out), 32'(exp_bits[b]));
            else if (b <= n)  check({"R3 data bit ", tag}, 32'(tx_out), 32'(exp_bits[b]));
            else              check({"R5/R6 parity ", tag}, 32'(tx_out), 32'(exp_bits[b]));
            ticks(8);
        end
        cnt = 0;
        while (!tx_ready && cnt < 40) begin
            if (tx_out !== 1'b1) check({"R7 stop level ", tag}, 32'(tx_out), 32'd1);
            tick();
            cnt++;
        end
        check({"R7 stop ticks ", tag}, 32'(cnt), 32'(stop_exp));
        line_ctrl = 7'h00;
    endtask

    task automatic t_break();
        int cnt;
        line_ctrl = 7'h43;
        #1;
        check("R8 line low", 32'(tx_out), 32'd0);
        check("R8 no ready", 32'(tx_ready), 32'd0);
        @(negedge clk);
        ticks(20);
        check("R8 held low", 32'(tx_out), 32'd0);
        check("R8 not busy", 32'(tx_busy), 32'd0);
        line_ctrl = 7'h03;
        #1;
        check("R9 mark after release", 32'(tx_out), 32'd1);
        check("R9 ready held", 32'(tx_ready), 32'd0);
        cnt = 0;
        while (!tx_ready && cnt < 40) begin
            tick();
            cnt++;
        end
        check("R9 guard ticks", 32'(cnt), 32'd16);
        check("R9 mark at end", 32'(tx_out), 32'd1);
    endtask

    initial begin
        t_reset();
        t_frame("8N1", 8'hA5, 7'h03, 7'h03);                    // R3 R4 R7
        t_frame("5N1 upper ignored", 8'hE6, 7'h00, 7'h00);      // R3
        t_frame("7 odd", 8'h13, 7'h0A, 7'h0A);                  // R5
        t_frame("6 even", 8'h07, 7'h19, 7'h19);                 // R5
        t_frame("8 mark", 8'hFF, 7'h2B, 7'h2B);                 // R6
        t_frame("8 space", 8'h00, 7'h3B, 7'h3B);                // R6
        t_frame("5 long stop", 8'h15, 7'h04, 7'h04);            // R7 1.5
        t_frame("6 long stop", 8'h2A, 7'h05, 7'h05);            // R7 2
        t_frame("R10 capture", 8'h5C, 7'h0F, 7'h30);            // R10
        t_break();                                              // R8 R9
        t_frame("after break", 8'h81, 7'h03, 7'h03);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule